// File: doc/BRIEF.md
# IDE Register Bridge with Interrupt State

This block is the memory-mapped front end of an IDE disk channel. A 32-bit host bus reaches it through a 4 KB window. The window is split into register slots 16 bytes apart, so the slot number is the byte address shifted right by four. Each slot accepts only certain access widths. Legal accesses to the data port, the task-file registers and the alternate-status/device-control register are passed to an attached IDE core as a single-cycle strobe. The IDE core is outside this block and is reached only through a small strobe interface.

The bridge itself holds two registers. One is a 32-bit timing word that software sets and reads back. The other is an interrupt state word. In that word, bit 31 is set when the DMA interrupt line rises, is cleared when the line falls, and can be cleared by software with a write-one-to-clear. Bit 30 follows the disk interrupt level. Both interrupt inputs are also passed straight through to their own output pins.

A read returns its data one cycle after the request. Any read that the decoder rejects returns all ones. A rejected write is dropped and causes no side effect.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The slot is selected by req_addr[11:4]. The low four address bits never change which register is hit, so addresses 0x200 and 0x20C reach the same register.
- R2: Slot 0 reads go to the core's data port. A 1-byte read issues a 16-bit core read (core_kind 0) and returns only bits 7:0 of core_rdata. A 2-byte read issues a 16-bit core read and returns bits 15:0. A 4-byte read issues a 32-bit core read (core_kind 1) and returns all 32 bits.
- R3: A 1-byte write to slot 0 raises no core strobe. A 2-byte write to slot 0 raises core_wr with core_kind 0 and core_wdata equal to the zero-extended bits 15:0 of the write data. A 4-byte write raises core_wr with core_kind 1 and the full write data.
- R4: Slots 1 to 7 are task-file registers (core_kind 2). They accept only 1-byte accesses. core_reg carries the slot number, a read returns bits 7:0 of core_rdata, and a write sends bits 7:0 of the write data.
- R5: Slots 0x08 and 0x16 both map to the alternate-status/device-control register (core_kind 3). They accept only 1-byte accesses and read back bits 7:0 of core_rdata.
- R6: Slot 0x20 holds a 32-bit timing word. It is written and read only with 4-byte accesses. An access of any other width leaves it unchanged.
- R7: The interrupt state word is read at slot 0x30 with 4-byte reads. Bit 31 is set on a rising edge of dma_irq_in and cleared on a falling edge. Bit 30 equals disk_irq_in as sampled at the previous clock edge. All other bits read 0.
- R8: A 4-byte write to slot 0x30 with bit 31 set clears bit 31 of the interrupt state word. Bit 30 and all other written bits have no effect. A rising DMA edge in the same cycle takes priority and leaves bit 31 set.
- R9: A read returns 0xFFFFFFFF when it hits an unmapped slot or uses a width the slot does not accept. Widths 3, 0 and 5 to 7 are accepted by no slot. No core strobe is raised for such a read.
- R10: A write to an unmapped slot, or with a width the slot does not accept, raises no core strobe and changes no register.
- R11: After reset the timing word and the interrupt state word are both 0, and rsp_valid is low.
- R12: dma_irq_out and disk_irq_out equal dma_irq_in and disk_irq_in in the same cycle, with no register in the path.
- R13: Core strobes, core_kind, core_reg and core_wdata are combinational and valid in the request cycle. rsp_valid and rsp_rdata appear one clock edge after a read request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access in this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte address within the window |
| req_bytes | input | 3 | Access width in bytes (1, 2 or 4 are decoded) |
| req_wdata | input | 32 | Write data, little-endian, low bytes first |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| core_rd | output | 1 | Read strobe to the IDE core |
| core_wr | output | 1 | Write strobe to the IDE core |
| core_kind | output | 2 | 0 data16, 1 data32, 2 task file, 3 alt-status/control |
| core_reg | output | 3 | Task-file register number |
| core_wdata | output | 32 | Write data to the core, masked to the access width |
| core_rdata | input | 32 | Combinational read data from the core |
| dma_irq_in | input | 1 | DMA interrupt level |
| disk_irq_in | input | 1 | Disk interrupt level |
| dma_irq_out | output | 1 | Forwarded DMA interrupt |
| disk_irq_out | output | 1 | Forwarded disk interrupt |

## Verification
The core strobes and their kind, register number and data are due in the request cycle itself. The bench therefore samples them one time step after it drives the request, before the rising edge. Read data and rsp_valid are due one edge after the request, so they are sampled at the following falling edge. A change on an interrupt input reaches the state word at the next edge. For that reason the bench waits one full cycle after moving an input before it issues the read that checks it. The forwarded interrupt pins are checked in the same time step as the input change.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

    typedef enum logic [1:0] {
        CORE_DATA16   = 2'd0,
        CORE_DATA32   = 2'd1,
        CORE_TASKFILE = 2'd2,
        CORE_CTRL     = 2'd3
    } core_kind_e;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CORE   = 2'd1,
        SEL_TIMING = 2'd2,
        SEL_IRQ    = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        FMT_BYTE = 2'd0,
        FMT_HALF = 2'd1,
        FMT_WORD = 2'd2
    } fmt_e;

    typedef struct packed {
        sel_e       sel;
        core_kind_e kind;
        fmt_e       fmt;
        logic [2:0] reg_idx;
    } decode_t;

endpackage

// File: rtl/ide_slot_decode.sv
module ide_slot_decode
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SLOT_SHIFT  = 4,
    parameter int TASK_FIRST  = 1,
    parameter int TASK_LAST   = 7,
    parameter int ALT_SLOT_A  = 8'h08,
    parameter int ALT_SLOT_B  = 8'h16,
    parameter int TIMING_SLOT = 8'h20,
    parameter int IRQ_SLOT    = 8'h30
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bytes,
    input  logic              write,
    output decode_t           dec
);
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    logic [SLOT_W-1:0] slot;
    logic              is_b, is_h, is_w;

    assign slot = addr[ADDR_W-1:SLOT_SHIFT];
    assign is_b = (bytes == 3'd1);
    assign is_h = (bytes == 3'd2);
    assign is_w = (bytes == 3'd4);

    always_comb begin
        dec         = '0;
        dec.sel     = SEL_NONE;
        dec.kind    = CORE_DATA16;
        dec.fmt     = FMT_WORD;
        dec.reg_idx = 3'd0;
        if (slot == '0) begin
            if (is_b && !write) begin
                dec.sel  = SEL_CORE;
                dec.kind = CORE_DATA16;
                dec.fmt  = FMT_BYTE;
            end else if (is_h) begin
                dec.sel  = SEL_CORE;
                dec.kind = CORE_DATA16;
                dec.fmt  = FMT_HALF;
            end else if (is_w) begin
                dec.sel  = SEL_CORE;
                dec.kind = CORE_DATA32;
                dec.fmt  = FMT_WORD;
            end
        end else if (int'(slot) >= TASK_FIRST && int'(slot) <= TASK_LAST) begin
            if (is_b) begin
                dec.sel     = SEL_CORE;
                dec.kind    = CORE_TASKFILE;
                dec.fmt     = FMT_BYTE;
                dec.reg_idx = slot[2:0];
            end
        end else if (int'(slot) == ALT_SLOT_A || int'(slot) == ALT_SLOT_B) begin
            if (is_b) begin
                dec.sel  = SEL_CORE;
                dec.kind = CORE_CTRL;
                dec.fmt  = FMT_BYTE;
            end
        end else if (int'(slot) == TIMING_SLOT) begin
            if (is_w) dec.sel = SEL_TIMING;
        end else if (int'(slot) == IRQ_SLOT) begin
            if (is_w) dec.sel = SEL_IRQ;
        end
    end

endmodule

// File: rtl/ide_irq_state.sv
module ide_irq_state #(
    parameter int WORD_W   = 32,
    parameter int DMA_BIT  = 31,
    parameter int DISK_BIT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_in,
    input  logic              disk_in,
    input  logic              clr_dma,
    output logic [WORD_W-1:0] state_o
);
    typedef struct packed {
        logic dma;
        logic disk;
        logic dma_prev;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.dma_prev = dma_in;
        st_d.disk     = disk_in;
        if (dma_in && !st_q.dma_prev) begin
            st_d.dma = 1'b1;
        end else if (!dma_in && st_q.dma_prev) begin
            st_d.dma = 1'b0;
        end else if (clr_dma) begin
            st_d.dma = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        state_o           = '0;
        state_o[DMA_BIT]  = st_q.dma;
        state_o[DISK_BIT] = st_q.disk;
    end

    // R7: a rising DMA level sets the latched bit on the next edge
    assert_dma_rise_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_in) |=> state_o[DMA_BIT]);

    // R7: the disk bit tracks the disk level one edge late
    assert_disk_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disk_in) |=> !state_o[DISK_BIT]);

    // R8: software clear wins unless a new DMA edge arrives together with it
    assert_clear_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_dma && !$rose(dma_in)) |=> !state_o[DMA_BIT]);

endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SLOT_SHIFT  = 4,
    parameter int TIMING_SLOT = 8'h20,
    parameter int IRQ_SLOT    = 8'h30,
    parameter int DMA_BIT     = 31,
    parameter int DISK_BIT    = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_bytes,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              core_rd,
    output logic              core_wr,
    output logic [1:0]        core_kind,
    output logic [2:0]        core_reg,
    output logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic              dma_irq_in,
    input  logic              disk_irq_in,
    output logic              dma_irq_out,
    output logic              disk_irq_out
);
    localparam logic [DATA_W-1:0] MISS_VALUE = '1;
    localparam int                HALF_W     = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] timing;
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t           st_d, st_q;
    decode_t           dec;
    logic              irq_clr;
    logic [DATA_W-1:0] irq_word;

    ide_slot_decode #(
        .ADDR_W      (ADDR_W),
        .SLOT_SHIFT  (SLOT_SHIFT),
        .TIMING_SLOT (TIMING_SLOT),
        .IRQ_SLOT    (IRQ_SLOT)
    ) u_decode (
        .addr  (req_addr),
        .bytes (req_bytes),
        .write (req_write),
        .dec   (dec)
    );

    ide_irq_state #(
        .WORD_W   (DATA_W),
        .DMA_BIT  (DMA_BIT),
        .DISK_BIT (DISK_BIT)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .dma_in  (dma_irq_in),
        .disk_in (disk_irq_in),
        .clr_dma (irq_clr),
        .state_o (irq_word)
    );

    assign dma_irq_out  = dma_irq_in;
    assign disk_irq_out = disk_irq_in;

    assign core_rd   = req_valid && !req_write && (dec.sel == SEL_CORE);
    assign core_wr   = req_valid &&  req_write && (dec.sel == SEL_CORE);
    assign core_kind = dec.kind;
    assign core_reg  = dec.reg_idx;

    always_comb begin
        case (dec.fmt)
            FMT_BYTE: core_wdata = {{(DATA_W-8){1'b0}}, req_wdata[7:0]};
            FMT_HALF: core_wdata = {{(DATA_W-HALF_W){1'b0}}, req_wdata[HALF_W-1:0]};
            default:  core_wdata = req_wdata;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        irq_clr        = 1'b0;
        if (req_valid) begin
            if (req_write) begin
                if (dec.sel == SEL_TIMING) st_d.timing = req_wdata;
                if (dec.sel == SEL_IRQ && req_wdata[DMA_BIT]) irq_clr = 1'b1;
            end else begin
                st_d.rsp_valid = 1'b1;
                case (dec.sel)
                    SEL_CORE: begin
                        case (dec.fmt)
                            FMT_BYTE: st_d.rdata = {{(DATA_W-8){1'b0}}, core_rdata[7:0]};
                            FMT_HALF: st_d.rdata = {{(DATA_W-HALF_W){1'b0}}, core_rdata[HALF_W-1:0]};
                            default:  st_d.rdata = core_rdata;
                        endcase
                    end
                    SEL_TIMING: st_d.rdata = st_q.timing;
                    SEL_IRQ:    st_d.rdata = irq_word;
                    default:    st_d.rdata = MISS_VALUE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rdata;

    // R13: every read gets its response on the next edge
    assert_rsp_next_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R9: rejected reads answer with all ones
    assert_miss_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && dec.sel == SEL_NONE) |=> (rsp_rdata == MISS_VALUE));

    // R6: the timing word moves only on a legal timing write
    assert_timing_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && dec.sel == SEL_TIMING) |=> $stable(st_q.timing));

    // R10: a core strobe never appears for an undecodable width
    assert_strobe_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd || core_wr) |-> (req_bytes == 3'd1 || req_bytes == 3'd2 || req_bytes == 3'd4));

endmodule

// File: tb/ide_mmio_bridge_tb.sv
`timescale 1ns/1ps
module ide_mmio_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_bytes = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        core_rd, core_wr;
    logic [1:0]  core_kind;
    logic [2:0]  core_reg;
    logic [31:0] core_wdata;
    logic [31:0] core_rdata;
    logic        dma_irq_in = 1'b0;
    logic        disk_irq_in = 1'b0;
    logic        dma_irq_out, disk_irq_out;

    int tests = 0;
    int fails = 0;

    logic        cap_rd, cap_wr, cap_rv;
    logic [1:0]  cap_kind;
    logic [2:0]  cap_reg;
    logic [31:0] cap_wdata, cap_rdata;

    always #10 clk = ~clk;

    // Core model: a recognisable pattern tagged with kind and register
    assign core_rdata = 32'hA1B2_C380 | {25'd0, core_kind, 1'b0, core_reg};

    ide_mmio_bridge u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_bytes    (req_bytes),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .core_rd      (core_rd),
        .core_wr      (core_wr),
        .core_kind    (core_kind),
        .core_reg     (core_reg),
        .core_wdata   (core_wdata),
        .core_rdata   (core_rdata),
        .dma_irq_in   (dma_irq_in),
        .disk_irq_in  (disk_irq_in),
        .dma_irq_out  (dma_irq_out),
        .disk_irq_out (disk_irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic do_read(input logic [11:0] a, input logic [2:0] b);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_bytes = b;
        #1;
        cap_rd = core_rd; cap_wr = core_wr; cap_kind = core_kind; cap_reg = core_reg;
        @(negedge clk);
        req_valid = 1'b0;
        cap_rv = rsp_valid; cap_rdata = rsp_rdata;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [2:0] b, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_bytes = b; req_wdata = d;
        #1;
        cap_rd = core_rd; cap_wr = core_wr; cap_kind = core_kind;
        cap_reg = core_reg; cap_wdata = core_wdata;
        @(negedge clk);
        req_valid = 1'b0;
        cap_rv = rsp_valid;
    endtask

    task automatic t_reset();
        chk("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        do_read(12'h200, 3'd4);
        chk("R11 timing reset", cap_rdata, 32'h0);
        chk("R13 read response valid", {31'd0, cap_rv}, 32'd1);
        do_read(12'h300, 3'd4);
        chk("R11 irq state reset", cap_rdata, 32'h0);
    endtask

    task automatic t_data_port();
        do_read(12'h000, 3'd1);
        chk("R2 byte read strobe", {31'd0, cap_rd}, 32'd1);
        chk("R2 byte read kind", {30'd0, cap_kind}, 32'd0);
        chk("R2 byte read data", cap_rdata, 32'h0000_0080);
        do_read(12'h000, 3'd2);
        chk("R2 half read data", cap_rdata, 32'h0000_C380);
        do_read(12'h000, 3'd4);
        chk("R2 word read kind", {30'd0, cap_kind}, 32'd1);
        chk("R2 word read data", cap_rdata, 32'hA1B2_C390);
        do_write(12'h000, 3'd1, 32'h0000_00EE);
        chk("R3 byte write no strobe", {31'd0, cap_wr}, 32'd0);
        do_write(12'h000, 3'd2, 32'hABCD_1234);
        chk("R3 half write strobe", {31'd0, cap_wr}, 32'd1);
        chk("R3 half write data", cap_wdata, 32'h0000_1234);
        chk("R3 half write kind", {30'd0, cap_kind}, 32'd0);
        do_write(12'h000, 3'd4, 32'hABCD_1234);
        chk("R3 word write data", cap_wdata, 32'hABCD_1234);
        chk("R3 word write kind", {30'd0, cap_kind}, 32'd1);
        chk("R13 write no response", {31'd0, cap_rv}, 32'd0);
        do_read(12'h000, 3'd3);
        chk("R9 width 3 read data", cap_rdata, 32'hFFFF_FFFF);
        chk("R9 width 3 no strobe", {31'd0, cap_rd}, 32'd0);
    endtask

    task automatic t_taskfile();
        do_read(12'h030, 3'd1);
        chk("R4 taskfile read kind", {30'd0, cap_kind}, 32'd2);
        chk("R4 taskfile read reg", {29'd0, cap_reg}, 32'd3);
        chk("R4 taskfile read data", cap_rdata, 32'h0000_00A3);
        do_read(12'h010, 3'd2);
        chk("R4 taskfile half read rejected", cap_rdata, 32'hFFFF_FFFF);
        chk("R4 taskfile half read no strobe", {31'd0, cap_rd}, 32'd0);
        do_write(12'h070, 3'd1, 32'h1234_565A);
        chk("R4 taskfile write strobe", {31'd0, cap_wr}, 32'd1);
        chk("R4 taskfile write reg", {29'd0, cap_reg}, 32'd7);
        chk("R4 taskfile write data", cap_wdata, 32'h0000_005A);
        do_write(12'h050, 3'd4, 32'h1111_1111);
        chk("R10 taskfile word write no strobe", {31'd0, cap_wr}, 32'd0);
    endtask

    task automatic t_altstat();
        do_read(12'h080, 3'd1);
        chk("R5 slot 0x08 read data", cap_rdata, 32'h0000_00B0);
        do_read(12'h160, 3'd1);
        chk("R5 slot 0x16 read data", cap_rdata, 32'h0000_00B0);
        do_write(12'h160, 3'd1, 32'h0000_0006);
        chk("R5 control write strobe", {31'd0, cap_wr}, 32'd1);
        chk("R5 control write kind", {30'd0, cap_kind}, 32'd3);
        do_read(12'h080, 3'd4);
        chk("R5 word read rejected", cap_rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_timing();
        do_write(12'h200, 3'd4, 32'h1234_5678);
        chk("R6 timing write no core strobe", {31'd0, cap_wr}, 32'd0);
        do_read(12'h200, 3'd4);
        chk("R6 timing readback", cap_rdata, 32'h1234_5678);
        do_read(12'h20C, 3'd4);
        chk("R1 low nibble ignored", cap_rdata, 32'h1234_5678);
        do_write(12'h200, 3'd2, 32'hFFFF_FFFF);
        do_write(12'h204, 3'd1, 32'hFFFF_FFFF);
        do_read(12'h200, 3'd4);
        chk("R6 narrow writes ignored", cap_rdata, 32'h1234_5678);
        do_read(12'h200, 3'd2);
        chk("R6 half read rejected", cap_rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        disk_irq_in = 1'b1;
        #1;
        chk("R12 disk forward", {31'd0, disk_irq_out}, 32'd1);
        @(negedge clk);
        do_read(12'h300, 3'd4);
        chk("R7 disk bit set", cap_rdata, 32'h4000_0000);
        dma_irq_in = 1'b1;
        #1;
        chk("R12 dma forward", {31'd0, dma_irq_out}, 32'd1);
        @(negedge clk);
        do_read(12'h300, 3'd4);
        chk("R7 dma bit set", cap_rdata, 32'hC000_0000);
        do_write(12'h300, 3'd4, 32'h7FFF_FFFF);
        do_read(12'h300, 3'd4);
        chk("R8 write without bit 31 no effect", cap_rdata, 32'hC000_0000);
        do_write(12'h300, 3'd4, 32'h8000_0000);
        do_read(12'h300, 3'd4);
        chk("R8 clear with level still high", cap_rdata, 32'h4000_0000);
        dma_irq_in = 1'b0;
        @(negedge clk);
        dma_irq_in = 1'b1;
        @(negedge clk);
        do_read(12'h300, 3'd4);
        chk("R7 new rise sets again", cap_rdata, 32'hC000_0000);
        dma_irq_in = 1'b0;
        disk_irq_in = 1'b0;
        #1;
        chk("R12 forward low", {30'd0, dma_irq_out, disk_irq_out}, 32'd0);
        @(negedge clk);
        do_read(12'h300, 3'd4);
        chk("R7 falls clear both bits", cap_rdata, 32'h0000_0000);
        do_read(12'h300, 3'd2);
        chk("R9 irq half read rejected", cap_rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_unmapped();
        do_read(12'h400, 3'd4);
        chk("R9 unmapped read", cap_rdata, 32'hFFFF_FFFF);
        do_read(12'h090, 3'd1);
        chk("R9 slot 9 read", cap_rdata, 32'hFFFF_FFFF);
        chk("R9 slot 9 no strobe", {31'd0, cap_rd}, 32'd0);
        do_write(12'h400, 3'd4, 32'hDEAD_BEEF);
        chk("R10 unmapped write no strobe", {30'd0, cap_rd, cap_wr}, 32'd0);
        do_read(12'h200, 3'd4);
        chk("R10 timing untouched", cap_rdata, 32'h1234_5678);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_port();
        t_taskfile();
        t_altstat();
        t_timing();
        t_irq();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule